// File: doc/BRIEF.md
# Multi-Mode Peak Level Tracker

This block follows the positive and negative peak amplitudes of a filtered, sampled received signal and presents their midpoint as a slicing threshold for a downstream bit decision. It holds two peak registers, one for each polarity. A level-acquire request and an active-low hold input select how fast those registers follow the signal and when they stop.

Raising the acquire request starts a short clamp phase. The clamp pulls both registers rapidly toward half of the incoming sample. While acquire stays high after the clamp, the block captures peaks fast. With acquire low, it settles into a slower averaging measurement. When hold is asserted, the registers freeze and only drift slowly back toward zero, so that the threshold survives a signal fade.

Samples arrive as 12-bit two's complement values, qualified by a sample enable. A bit strobe marks bit boundaries. The peak registers keep four extra fraction bits, so the slow leak and decay steps do not vanish.

Top module: `peak_tracker`

## Requirements
- R1: Reset (rstN low) clears posPeak, negPeak and threshold to zero.
- R2: A rising acqReq starts the clamp mode in that same cycle. Clamp continues through the first bitStrobe seen after the rising cycle; a strobe in the rising cycle itself does not end it. Clamp does not depend on holdN. On each valid sample during clamp, both registers take reg + ((sampleIn*16/2 - reg) >>> 1).
- R3: With acqReq high and no clamp, each valid sample is handled as follows. posPeak is loaded with the sample if the sample is above it, and otherwise becomes posPeak - (posPeak >>> 8). negPeak mirrors this for samples below it. holdN has no effect in this mode.
- R4: With acqReq low and holdN high, a register updates only on a cycle with both sampleValid and bitStrobe. A sample above the current threshold moves posPeak by (x - posPeak) >>> 3. A sample below it moves negPeak by (x - negPeak) >>> 3.
- R5: With acqReq low and holdN low, samples are ignored. On each bitStrobe, each register becomes reg - (reg >>> 11), a slow decay toward zero.
- R6: threshold equals floor((posPeak + negPeak) / 2), summed one bit wider so that the result never overflows.
- R7: In clamp, fast and averaging modes, a cycle without sampleValid leaves both registers unchanged.
- R8: Every output is 16-bit two's complement with 4 fraction bits, so a sample value v appears as v*16. Arithmetic right shifts round toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 12 | Signed filtered sample |
| sampleValid | input | 1 | Sample enable |
| bitStrobe | input | 1 | One-cycle pulse per bit period |
| acqReq | input | 1 | Level-acquire request |
| holdN | input | 1 | Hold, active low |
| posPeak | output | 16 | Positive peak register |
| negPeak | output | 16 | Negative peak register |
| threshold | output | 16 | Midpoint of the two peaks |

## Verification
A single cycle-by-cycle trace walks the block through clamp, fast capture, averaging, hold, a second clamp and full-scale samples. Within that trace, samples above, below and between the peaks separate the capture branch from the leak branch, and the positive register from the negative one. Rows with no sample enable or no bit strobe show that averaging and clamp wait for their qualifiers, while hold-mode rows with large samples show that the input is ignored. Full-scale opposite peaks probe the widened threshold sum, and a reset in the middle of the run confirms that all state clears.

// File: rtl/peak_trk_pkg.sv
package peak_trk_pkg;
  typedef enum logic [1:0] {
    MODE_CLAMP = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_AVG   = 2'd2,
    MODE_HOLD  = 2'd3
  } trkMode_e;

  typedef struct packed {
    trkMode_e mode;
    logic     sampleStep;
    logic     bitStep;
  } trkCtrl_t;
endpackage

// File: rtl/peak_trk_ctrl.sv
module peak_trk_ctrl
  import peak_trk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleValid,
  input  logic     bitStrobe,
  input  logic     acqReq,
  input  logic     holdN,
  output trkCtrl_t ctrlOut
);
  logic acqPrev;
  logic clampBusy;
  logic acqRise;
  logic clampNow;

  assign acqRise  = acqReq & ~acqPrev;
  assign clampNow = acqRise | clampBusy;

  // Clamp lasts until the first bit strobe after the rising cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acqPrev   <= 1'b0;
      clampBusy <= 1'b0;
    end else begin
      acqPrev <= acqReq;
      if (acqRise)
        clampBusy <= 1'b1;
      else if (clampBusy && bitStrobe)
        clampBusy <= 1'b0;
    end
  end

  always_comb begin
    ctrlOut.sampleStep = sampleValid;
    ctrlOut.bitStep    = bitStrobe;
    if (clampNow)
      ctrlOut.mode = MODE_CLAMP;
    else if (acqReq)
      ctrlOut.mode = MODE_FAST;
    else if (holdN)
      ctrlOut.mode = MODE_AVG;
    else
      ctrlOut.mode = MODE_HOLD;
  end
endmodule

// File: rtl/peak_trk_cell.sv
module peak_trk_cell
  import peak_trk_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter bit IS_POS      = 1'b1,
  parameter int LEAK_SHIFT  = 8,
  parameter int AVG_SHIFT   = 3,
  parameter int DECAY_SHIFT = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  trkCtrl_t                ctrlIn,
  input  logic signed [REG_W-1:0] sampleExt,
  input  logic signed [REG_W-1:0] threshIn,
  output logic signed [REG_W-1:0] peakVal
);
  localparam int EXT_W = REG_W + 1;

  logic signed [EXT_W-1:0] peakW;
  logic signed [EXT_W-1:0] xW;
  logic signed [EXT_W-1:0] thrW;
  logic signed [EXT_W-1:0] clampTgt;
  logic signed [EXT_W-1:0] clampNext;
  logic signed [EXT_W-1:0] leakNext;
  logic signed [EXT_W-1:0] avgNext;
  logic signed [EXT_W-1:0] decayNext;
  logic signed [REG_W-1:0] peakNext;
  logic beyond;
  logic avgQual;

  assign peakW    = {peakVal[REG_W-1], peakVal};
  assign xW       = {sampleExt[REG_W-1], sampleExt};
  assign thrW     = {threshIn[REG_W-1], threshIn};
  assign clampTgt = xW >>> 1;

  assign clampNext = peakW + ((clampTgt - peakW) >>> 1);
  assign leakNext  = peakW - (peakW >>> LEAK_SHIFT);
  assign avgNext   = peakW + ((xW - peakW) >>> AVG_SHIFT);
  assign decayNext = peakW - (peakW >>> DECAY_SHIFT);

  generate
    if (IS_POS) begin : g_pos
      assign beyond  = xW > peakW;
      assign avgQual = xW > thrW;
    end else begin : g_neg
      assign beyond  = xW < peakW;
      assign avgQual = xW < thrW;
    end
  endgenerate

  always_comb begin
    peakNext = peakVal;
    unique case (ctrlIn.mode)
      MODE_CLAMP: if (ctrlIn.sampleStep) peakNext = clampNext[REG_W-1:0];
      MODE_FAST: begin
        if (ctrlIn.sampleStep)
          peakNext = beyond ? sampleExt : leakNext[REG_W-1:0];
      end
      MODE_AVG: begin
        if (ctrlIn.sampleStep && ctrlIn.bitStep && avgQual)
          peakNext = avgNext[REG_W-1:0];
      end
      MODE_HOLD: if (ctrlIn.bitStep) peakNext = decayNext[REG_W-1:0];
      default: peakNext = peakVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) peakVal <= '0;
    else       peakVal <= peakNext;
  end
endmodule

// File: rtl/peak_trk_datapath.sv
module peak_trk_datapath
  import peak_trk_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int FRAC_W      = 4,
  parameter int LEAK_SHIFT  = 8,
  parameter int AVG_SHIFT   = 3,
  parameter int DECAY_SHIFT = 11,
  localparam int REG_W      = SAMPLE_W + FRAC_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  trkCtrl_t                   ctrlIn,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [REG_W-1:0]    posPeak,
  output logic signed [REG_W-1:0]    negPeak,
  output logic signed [REG_W-1:0]    threshold
);
  localparam int NUM_CELLS = 2;

  logic signed [REG_W-1:0] sampleExt;
  logic signed [REG_W:0]   peakSum;
  logic signed [REG_W-1:0] peaks [NUM_CELLS];

  assign sampleExt = {sampleIn, {FRAC_W{1'b0}}};
  assign peakSum   = {peaks[0][REG_W-1], peaks[0]} + {peaks[1][REG_W-1], peaks[1]};
  assign threshold = peakSum[REG_W:1];
  assign posPeak   = peaks[0];
  assign negPeak   = peaks[1];

  generate
    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
      peak_trk_cell #(
        .REG_W      (REG_W),
        .IS_POS     (g == 0),
        .LEAK_SHIFT (LEAK_SHIFT),
        .AVG_SHIFT  (AVG_SHIFT),
        .DECAY_SHIFT(DECAY_SHIFT)
      ) u_cell (
        .clk      (clk),
        .rstN     (rstN),
        .ctrlIn   (ctrlIn),
        .sampleExt(sampleExt),
        .threshIn (threshold),
        .peakVal  (peaks[g])
      );
    end
  endgenerate
endmodule

// File: rtl/peak_tracker.sv
module peak_tracker
  import peak_trk_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int FRAC_W      = 4,
  parameter int LEAK_SHIFT  = 8,
  parameter int AVG_SHIFT   = 3,
  parameter int DECAY_SHIFT = 11,
  localparam int REG_W      = SAMPLE_W + FRAC_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic                       bitStrobe,
  input  logic                       acqReq,
  input  logic                       holdN,
  output logic signed [REG_W-1:0]    posPeak,
  output logic signed [REG_W-1:0]    negPeak,
  output logic signed [REG_W-1:0]    threshold
);
  trkCtrl_t ctrlBus;

  peak_trk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .bitStrobe  (bitStrobe),
    .acqReq     (acqReq),
    .holdN      (holdN),
    .ctrlOut    (ctrlBus)
  );

  peak_trk_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .FRAC_W     (FRAC_W),
    .LEAK_SHIFT (LEAK_SHIFT),
    .AVG_SHIFT  (AVG_SHIFT),
    .DECAY_SHIFT(DECAY_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .sampleIn (sampleIn),
    .posPeak  (posPeak),
    .negPeak  (negPeak),
    .threshold(threshold)
  );
endmodule

// File: rtl/peak_tracker_chk.sv
module peak_tracker_chk
  import peak_trk_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FRAC_W   = 4,
  localparam int REG_W   = SAMPLE_W + FRAC_W
) (
  input logic                       clk,
  input logic                       rstN,
  input logic signed [SAMPLE_W-1:0] sampleIn,
  input logic                       sampleValid,
  input logic                       bitStrobe,
  input logic                       acqReq,
  input logic signed [REG_W-1:0]    posPeak,
  input logic signed [REG_W-1:0]    negPeak,
  input logic signed [REG_W-1:0]    threshold,
  input trkCtrl_t                   ctrlBus
);
  logic signed [REG_W-1:0] chkExt;
  assign chkExt = {sampleIn, {FRAC_W{1'b0}}};

  p_clamp_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acqReq) |-> ctrlBus.mode == MODE_CLAMP);

  p_clamp_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.mode == MODE_CLAMP && bitStrobe && !$rose(acqReq))
      |=> (ctrlBus.mode != MODE_CLAMP || $rose(acqReq)));

  p_fast_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.mode == MODE_FAST && sampleValid && chkExt > posPeak)
      |=> posPeak == $past(chkExt));

  p_avg_waits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.mode == MODE_AVG && !(sampleValid && bitStrobe))
      |=> ($stable(posPeak) && $stable(negPeak)));

  p_hold_still_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.mode == MODE_HOLD && !bitStrobe)
      |=> ($stable(posPeak) && $stable(negPeak)));

  p_thr_between_r6: assert property (@(posedge clk) disable iff (!rstN)
    (posPeak >= negPeak) |-> (threshold <= posPeak && threshold >= negPeak));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.mode != MODE_HOLD && !sampleValid)
      |=> ($stable(posPeak) && $stable(negPeak)));
endmodule

bind peak_tracker peak_tracker_chk #(
  .SAMPLE_W(SAMPLE_W),
  .FRAC_W  (FRAC_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleIn   (sampleIn),
  .sampleValid(sampleValid),
  .bitStrobe  (bitStrobe),
  .acqReq     (acqReq),
  .posPeak    (posPeak),
  .negPeak    (negPeak),
  .threshold  (threshold),
  .ctrlBus    (ctrlBus)
);

// File: tb/tb_peak_tracker.sv
module tb_peak_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 17;

  typedef struct packed {
    logic               acq;
    logic               hldN;
    logic               vld;
    logic               stb;
    logic signed [11:0] smp;
    logic signed [15:0] ePos;
    logic signed [15:0] eNeg;
  } vec_t;

  // acq, holdN, valid, strobe, sample, expected pos, expected neg
  localparam vec_t VECS [NUM_VEC] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0,  12'sd100,  16'sd400,    16'sd400},   // R2 rise
    '{1'b1, 1'b1, 1'b1, 1'b0,  12'sd100,  16'sd600,    16'sd600},   // R2
    '{1'b1, 1'b1, 1'b1, 1'b1,  12'sd100,  16'sd700,    16'sd700},   // R2 last
    '{1'b1, 1'b1, 1'b1, 1'b0,  12'sd200,  16'sd3200,   16'sd698},   // R3
    '{1'b1, 1'b0, 1'b1, 1'b0, -12'sd50,   16'sd3188,  -16'sd800},   // R3 holdN ignored
    '{1'b1, 1'b1, 1'b0, 1'b0,  12'sd0,    16'sd3188,  -16'sd800},   // R7
    '{1'b0, 1'b1, 1'b1, 1'b1,  12'sd300,  16'sd3389,  -16'sd800},   // R4
    '{1'b0, 1'b1, 1'b1, 1'b1, -12'sd100,  16'sd3389,  -16'sd900},   // R4
    '{1'b0, 1'b1, 1'b1, 1'b0,  12'sd500,  16'sd3389,  -16'sd900},   // R4 no strobe
    '{1'b0, 1'b0, 1'b1, 1'b1,  12'sd1000, 16'sd3388,  -16'sd899},   // R5
    '{1'b0, 1'b0, 1'b1, 1'b0,  12'sd1000, 16'sd3388,  -16'sd899},   // R5
    '{1'b1, 1'b0, 1'b1, 1'b1,  12'sd0,    16'sd1694,  -16'sd450},   // R2 strobe in rise cycle
    '{1'b1, 1'b0, 1'b1, 1'b0,  12'sd0,    16'sd847,   -16'sd225},   // R2
    '{1'b1, 1'b1, 1'b1, 1'b1, -12'sd10,   16'sd383,   -16'sd153},   // R2 last, R8
    '{1'b1, 1'b1, 1'b1, 1'b0,  12'sd0,    16'sd382,   -16'sd152},   // R3 leak
    '{1'b1, 1'b1, 1'b1, 1'b0,  12'sd2047, 16'sd32752, -16'sd151},   // R3 full scale
    '{1'b1, 1'b1, 1'b1, 1'b0, -12'sd2048, 16'sd32625, -16'sd32768}  // R6 wide sum
  };

  logic               clk = 1'b0;
  logic               rstN;
  logic signed [11:0] sampleIn;
  logic               sampleValid;
  logic               bitStrobe;
  logic               acqReq;
  logic               holdN;
  logic signed [15:0] posPeak;
  logic signed [15:0] negPeak;
  logic signed [15:0] threshold;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  peak_tracker dut (
    .clk        (clk),
    .rstN       (rstN),
    .sampleIn   (sampleIn),
    .sampleValid(sampleValid),
    .bitStrobe  (bitStrobe),
    .acqReq     (acqReq),
    .holdN      (holdN),
    .posPeak    (posPeak),
    .negPeak    (negPeak),
    .threshold  (threshold)
  );

  function automatic string rowTag(int i);
    case (i)
      0, 1, 2, 11, 12: return "R2";
      3, 4, 14, 15:    return "R3";
      5:               return "R7";
      6, 7, 8:         return "R4";
      9, 10:           return "R5";
      13:              return "R8";
      default:         return "R6";
    endcase
  endfunction

  task automatic check(string tag, string what, logic signed [15:0] got,
                       logic signed [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic signed [15:0] midOf(logic signed [15:0] a,
                                               logic signed [15:0] b);
    logic signed [16:0] s;
    s = 17'(a) + 17'(b);
    return s[16:1];
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; sampleIn = '0; sampleValid = 1'b0;
    bitStrobe = 1'b0; acqReq = 1'b0; holdN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", "pos after reset", posPeak, 16'sd0);
    check("R1", "neg after reset", negPeak, 16'sd0);
    check("R1", "thr after reset", threshold, 16'sd0);

    for (int i = 0; i < NUM_VEC; i++) begin
      @(negedge clk);
      acqReq = VECS[i].acq; holdN = VECS[i].hldN;
      sampleValid = VECS[i].vld; bitStrobe = VECS[i].stb;
      sampleIn = VECS[i].smp;
      @(posedge clk); #1;
      check(rowTag(i), $sformatf("pos row %0d", i), posPeak, VECS[i].ePos);
      check(rowTag(i), $sformatf("neg row %0d", i), negPeak, VECS[i].eNeg);
      check("R6", $sformatf("thr row %0d", i), threshold,
            midOf(VECS[i].ePos, VECS[i].eNeg));
    end

    // Directed: full-scale opposite peaks give threshold -72 (R6)
    check("R6", "full-scale threshold", threshold, -16'sd72);

    // Directed: reset in mid-run clears all state (R1)
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1", "pos mid reset", posPeak, 16'sd0);
    check("R1", "neg mid reset", negPeak, 16'sd0);
    check("R1", "thr mid reset", threshold, 16'sd0);
    @(negedge clk);
    rstN = 1'b1; acqReq = 1'b0; sampleValid = 1'b0; bitStrobe = 1'b0;

    // Directed: hold decay from zero stays at zero (R5)
    @(negedge clk);
    holdN = 1'b0; bitStrobe = 1'b1; sampleValid = 1'b1; sampleIn = 12'sd700;
    @(posedge clk); #1;
    check("R5", "hold from zero pos", posPeak, 16'sd0);
    check("R5", "hold from zero neg", negPeak, 16'sd0);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule